// File: doc/BRIEF.md
# Processor Interrupt Entry Controller

This block sits next to a small 32-bit processor core and decides, clock by clock, whether the core must leave its current instruction stream. There are three kinds of request. A reset request restarts the core. A non-maskable request can be held off only by an entry already in progress. Six maskable request lines can also be held off by the interrupt-disable flag. When a request is taken, the block registers a redirect strobe together with the target address and the new status word. It also records the interrupted program counter and status word in shadow registers, and it updates a 32-bit cause register.

The core supplies its current program counter and status word on every cycle. Each request line is latched on its rising edge. The latched request stays pending until it is taken, so a request that arrives while entry is blocked is retried on every later cycle. At most one entry happens per clock. Every result is registered, and the redirect strobe lasts one cycle.

Top module: `irq_entry_ctrl`

## Requirements
- R1: A high `rst_req` at a clock edge wins over every other request. After that edge `redir_vld`=1, `redir_pc`=0, `new_psw`=0x20 and `cause`=0, and all latched requests are dropped.
- R2: A latched non-maskable request is taken only at an edge where `cur_psw` bit 7 (entry-in-progress flag) is 0. Until then it stays pending and is retried every cycle.
- R3: Any number of non-maskable rising edges that arrive while the request is blocked produce exactly one entry.
- R4: A non-maskable entry loads `fe_pc`/`fe_psw` with `cur_pc`/`cur_psw` and sets `redir_pc` to 0x10. `new_psw` is `cur_psw` with bits 7 and 5 set and bit 6 cleared; all other bits pass through unchanged.
- R5: A non-maskable entry clears `cause[31:16]`, keeps `cause[15:0]`, and ORs 0x10 into the result.
- R6: A latched maskable request is taken only when `cur_psw` bits 7 and 5 are both 0. Otherwise it stays pending.
- R7: A maskable entry loads `ei_pc`/`ei_psw` with `cur_pc`/`cur_psw`. `new_psw` is `cur_psw` with bit 5 set and bit 6 cleared. `cause[31:16]` is kept and `cause[15:0]` becomes the source code.
- R8: Maskable line i (bit i of `irq_req`) has the code 0x80+0x10*i, and `redir_pc` equals that code.
- R9: Requests are latched on rising edges only. A line that is held high does not retrigger, and a latched request is cleared only when it is taken or by R1.
- R10: The non-maskable request has priority over the maskable lines. Among the maskable lines, the lowest index wins and the others stay pending. `redir_vld` is high only in the cycle after an entry.
- R11: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| rst_req | input | 1 | Core reset request (level) |
| nmi_req | input | 1 | Non-maskable request line |
| irq_req | input | 6 | Maskable request lines, bit 0 has the highest priority |
| cur_pc | input | 32 | Current program counter of the core |
| cur_psw | input | 32 | Current status word of the core |
| redir_vld | output | 1 | One-cycle redirect strobe |
| redir_pc | output | 32 | New program counter |
| new_psw | output | 32 | New status word |
| fe_pc | output | 32 | PC saved at non-maskable entry |
| fe_psw | output | 32 | Status word saved at non-maskable entry |
| ei_pc | output | 32 | PC saved at maskable entry |
| ei_psw | output | 32 | Status word saved at maskable entry |
| cause | output | 32 | Exception cause register |

## Verification
Every result appears one clock after the edge that samples the inputs that cause it. A rising request edge and the status word that allows it are examined at the same edge, and the redirect, the new status word, the shadow registers and the cause register all become visible after that edge. The bench drives each cycle's inputs after a falling edge and compares every output against its reference model 1 ns after the next rising edge. At that moment the results of that single edge, and nothing later, are visible. The directed checks of blocking, retry and priority read the outputs at this same point, one cycle after each step.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    localparam int unsigned DW = 32;

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] pc;
        logic [DW-1:0] psw;
        logic [DW-1:0] fe_pc;
        logic [DW-1:0] fe_psw;
        logic [DW-1:0] ei_pc;
        logic [DW-1:0] ei_psw;
        logic [DW-1:0] cause;
    } ent_state_t;

endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic flush_i,
    input  logic take_i,
    output logic live_o
);
    typedef struct packed {
        logic prev;
        logic pend;
    } lat_t;

    lat_t lat_d, lat_q;
    logic rise;

    always_comb begin
        rise       = req_i & ~lat_q.prev;
        live_o     = lat_q.pend | rise;
        lat_d.prev = req_i;
        if (flush_i || take_i) begin
            lat_d.pend = 1'b0;
        end else begin
            lat_d.pend = live_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else begin
            lat_q <= lat_d;
        end
    end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int unsigned N  = 6,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                any_o = 1'b1;
                idx_o = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
    import irq_entry_pkg::*;
#(
    parameter int unsigned   N_IRQ    = 6,
    parameter logic [DW-1:0] VEC_BASE = 32'h80,
    parameter logic [DW-1:0] VEC_STEP = 32'h10,
    parameter logic [DW-1:0] NMI_VEC  = 32'h10,
    parameter logic [DW-1:0] NMI_CODE = 32'h10,
    parameter logic [DW-1:0] RST_PSW  = 32'h20,
    parameter int unsigned   BIT_ID   = 5,
    parameter int unsigned   BIT_EP   = 6,
    parameter int unsigned   BIT_NP   = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rst_req,
    input  logic             nmi_req,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [DW-1:0]    cur_pc,
    input  logic [DW-1:0]    cur_psw,
    output logic             redir_vld,
    output logic [DW-1:0]    redir_pc,
    output logic [DW-1:0]    new_psw,
    output logic [DW-1:0]    fe_pc,
    output logic [DW-1:0]    fe_psw,
    output logic [DW-1:0]    ei_pc,
    output logic [DW-1:0]    ei_psw,
    output logic [DW-1:0]    cause
);
    localparam int unsigned   IW      = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;
    localparam int unsigned   HW      = DW / 2;
    localparam logic [DW-1:0] ID_MASK = DW'(1) << BIT_ID;
    localparam logic [DW-1:0] EP_MASK = DW'(1) << BIT_EP;
    localparam logic [DW-1:0] NP_MASK = DW'(1) << BIT_NP;
    localparam logic [DW-1:0] LO_MASK = {{HW{1'b0}}, {HW{1'b1}}};
    localparam logic [DW-1:0] HI_MASK = ~LO_MASK;

    ent_state_t st_d, st_q;

    logic             flush;
    logic             nmi_take;
    logic             nmi_live;
    logic [N_IRQ-1:0] irq_take;
    logic [N_IRQ-1:0] irq_live;
    logic             irq_any;
    logic [IW-1:0]    irq_idx;
    logic             nmi_ok;
    logic             irq_ok;
    logic [DW-1:0]    irq_code;

    irq_edge_latch u_nmi_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (nmi_req),
        .flush_i (flush),
        .take_i  (nmi_take),
        .live_o  (nmi_live)
    );

    for (genvar g = 0; g < N_IRQ; g++) begin : g_irq_lat
        irq_edge_latch u_lat (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_i   (irq_req[g]),
            .flush_i (flush),
            .take_i  (irq_take[g]),
            .live_o  (irq_live[g])
        );
    end

    irq_prio_pick #(.N(N_IRQ)) u_pick (
        .req_i (irq_live),
        .any_o (irq_any),
        .idx_o (irq_idx)
    );

    always_comb begin
        nmi_ok   = ~cur_psw[BIT_NP];
        irq_ok   = ~cur_psw[BIT_NP] & ~cur_psw[BIT_ID];
        irq_code = VEC_BASE + VEC_STEP * DW'(irq_idx);
        st_d     = st_q;
        st_d.vld = 1'b0;
        flush    = 1'b0;
        nmi_take = 1'b0;
        irq_take = '0;
        if (rst_req) begin
            flush      = 1'b1;
            st_d.vld   = 1'b1;
            st_d.pc    = '0;
            st_d.psw   = RST_PSW;
            st_d.cause = '0;
        end else if (nmi_live && nmi_ok) begin
            nmi_take    = 1'b1;
            st_d.vld    = 1'b1;
            st_d.pc     = NMI_VEC;
            st_d.psw    = (cur_psw | NP_MASK | ID_MASK) & ~EP_MASK;
            st_d.fe_pc  = cur_pc;
            st_d.fe_psw = cur_psw;
            st_d.cause  = (st_q.cause & LO_MASK) | NMI_CODE;
        end else if (irq_any && irq_ok) begin
            irq_take[irq_idx] = 1'b1;
            st_d.vld    = 1'b1;
            st_d.pc     = irq_code;
            st_d.psw    = (cur_psw | ID_MASK) & ~EP_MASK;
            st_d.ei_pc  = cur_pc;
            st_d.ei_psw = cur_psw;
            st_d.cause  = (st_q.cause & HI_MASK) | irq_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign redir_vld = st_q.vld;
    assign redir_pc  = st_q.pc;
    assign new_psw   = st_q.psw;
    assign fe_pc     = st_q.fe_pc;
    assign fe_psw    = st_q.fe_psw;
    assign ei_pc     = st_q.ei_pc;
    assign ei_psw    = st_q.ei_psw;
    assign cause     = st_q.cause;
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rst_req,
    input logic [31:0] cur_pc,
    input logic [31:0] cur_psw,
    input logic        redir_vld,
    input logic [31:0] redir_pc,
    input logic [31:0] new_psw,
    input logic [31:0] fe_pc,
    input logic [31:0] fe_psw,
    input logic [31:0] cause
);
    localparam logic [31:0] NMI_PC = 32'h10;

    AST_RST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> (redir_vld && redir_pc == 32'h0 && new_psw == 32'h20 && cause == 32'h0)); // R1

    AST_NMI_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_req && cur_psw[7]) |=> !(redir_vld && redir_pc == NMI_PC)); // R2

    AST_NMI_CTX: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_req && !cur_psw[7]) |=> (!(redir_vld && redir_pc == NMI_PC) ||
            (fe_pc == $past(cur_pc) && fe_psw == $past(cur_psw) &&
             new_psw[7] && new_psw[5] && !new_psw[6]))); // R4

    AST_MASK_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_req && (cur_psw[7] || cur_psw[5])) |=> !(redir_vld && redir_pc >= 32'h80)); // R6

    AST_MASK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_req && !cur_psw[7] && !cur_psw[5]) |=>
            (!(redir_vld && redir_pc >= 32'h80) ||
             (cause[31:16] == $past(cause[31:16]) && cause[15:0] == redir_pc[15:0]))); // R7
endmodule

bind irq_entry_ctrl irq_entry_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_req   (rst_req),
    .cur_pc    (cur_pc),
    .cur_psw   (cur_psw),
    .redir_vld (redir_vld),
    .redir_pc  (redir_pc),
    .new_psw   (new_psw),
    .fe_pc     (fe_pc),
    .fe_psw    (fe_psw),
    .cause     (cause)
);

// File: tb/irq_entry_ctrl_tb.sv
`timescale 1ns/1ps
module irq_entry_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rst_req = 1'b0;
    logic        nmi_req = 1'b0;
    logic [5:0]  irq_req = '0;
    logic [31:0] cur_pc = '0;
    logic [31:0] cur_psw = '0;
    logic        redir_vld;
    logic [31:0] redir_pc, new_psw, fe_pc, fe_psw, ei_pc, ei_psw, cause;

    int unsigned total = 0;
    int unsigned bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    irq_entry_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .nmi_req(nmi_req),
        .irq_req(irq_req), .cur_pc(cur_pc), .cur_psw(cur_psw),
        .redir_vld(redir_vld), .redir_pc(redir_pc), .new_psw(new_psw),
        .fe_pc(fe_pc), .fe_psw(fe_psw), .ei_pc(ei_pc), .ei_psw(ei_psw),
        .cause(cause)
    );

    // reference model state
    logic        m_pn, m_nn;
    logic [5:0]  m_pi, m_ni;
    logic        m_vld;
    logic [31:0] m_pc, m_psw, m_fepc, m_fepsw, m_eipc, m_eipsw, m_cause;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic void model(input logic r, input logic n, input logic [5:0] i,
                                  input logic [31:0] pc, input logic [31:0] psw);
        logic       ln;
        logic [5:0] li;
        int         k;
        ln = m_pn | (n & ~m_nn);
        li = m_pi | (i & ~m_ni);
        m_vld = 1'b0;
        m_pn = ln;
        m_pi = li;
        if (r) begin
            m_vld = 1'b1; m_pc = 0; m_psw = 32'h20; m_cause = 0;
            m_pn = 1'b0; m_pi = '0;
        end else if (ln && !psw[7]) begin
            m_vld = 1'b1; m_pc = 32'h10;
            m_psw = (psw | 32'hA0) & ~32'h40;
            m_fepc = pc; m_fepsw = psw;
            m_cause = {16'h0, m_cause[15:0]} | 32'h10;
            m_pn = 1'b0;
        end else if (li != 0 && !psw[7] && !psw[5]) begin
            k = 0;
            while (!li[k]) k++;
            m_vld = 1'b1; m_pc = 32'h80 + 32'h10 * k;
            m_psw = (psw | 32'h20) & ~32'h40;
            m_eipc = pc; m_eipsw = psw;
            m_cause = {m_cause[31:16], 16'h0} | m_pc;
            m_pi[k] = 1'b0;
        end
        m_nn = n;
        m_ni = i;
    endfunction

    task automatic step(input logic r, input logic n, input logic [5:0] i,
                        input logic [31:0] pc, input logic [31:0] psw);
        @(negedge clk);
        rst_req = r; nmi_req = n; irq_req = i; cur_pc = pc; cur_psw = psw;
        model(r, n, i, pc, psw);
        @(posedge clk);
        #1;
        chk("R10 redir_vld", 32'(redir_vld), 32'(m_vld));
        chk("R8 redir_pc", redir_pc, m_pc);
        chk("R4 new_psw", new_psw, m_psw);
        chk("R4 fe_pc", fe_pc, m_fepc);
        chk("R4 fe_psw", fe_psw, m_fepsw);
        chk("R7 ei_pc", ei_pc, m_eipc);
        chk("R7 ei_psw", ei_psw, m_eipsw);
        chk("R5 cause", cause, m_cause);
    endtask

    initial begin
        m_pn = 0; m_nn = 0; m_pi = 0; m_ni = 0; m_vld = 0;
        m_pc = 0; m_psw = 0; m_fepc = 0; m_fepsw = 0; m_eipc = 0; m_eipsw = 0; m_cause = 0;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        // R11: outputs are zero while the block is held in reset
        chk("R11 vld", 32'(redir_vld), 0);
        chk("R11 pc", redir_pc, 0);
        chk("R11 psw", new_psw, 0);
        chk("R11 cause", cause, 0);
        chk("R11 fe_pc", fe_pc, 0);
        chk("R11 ei_pc", ei_pc, 0);
        @(negedge clk);
        rst_n = 1'b1;

        step(0, 0, 6'h00, 32'h1000, 32'h0);
        // R2 / R3: NMI blocked by bit 7, two edges, one entry
        step(0, 1, 6'h00, 32'h1004, 32'h80);
        chk("R2 blocked", 32'(redir_vld), 0);
        step(0, 0, 6'h00, 32'h1008, 32'h80);
        step(0, 1, 6'h00, 32'h100C, 32'h80);
        step(0, 0, 6'h00, 32'h2000, 32'h0F);
        chk("R2 retried", redir_pc, 32'h10);
        chk("R4 psw", new_psw, 32'hAF);
        chk("R4 fe_pc", fe_pc, 32'h2000);
        step(0, 0, 6'h00, 32'h2004, 32'h0);
        chk("R3 single", 32'(redir_vld), 0);

        // R6 / R10 / R9: two maskable lines, blocked by bit 5
        step(0, 0, 6'b001010, 32'h3000, 32'h20);
        chk("R6 blocked", 32'(redir_vld), 0);
        step(0, 0, 6'b001010, 32'h3004, 32'h40);
        chk("R10 lowest", redir_pc, 32'h90);
        chk("R7 psw", new_psw, 32'h20);
        chk("R7 cause", cause, 32'h90);
        step(0, 0, 6'b001010, 32'h3008, 32'h0);
        chk("R9 pending kept", redir_pc, 32'hB0);
        step(0, 0, 6'b001010, 32'h300C, 32'h0);
        chk("R9 no retrigger", 32'(redir_vld), 0);

        // R5 / R8: cause low half kept by NMI
        step(0, 0, 6'b000100, 32'h4000, 32'h0);
        chk("R8 code 2", cause, 32'hA0);
        step(0, 0, 6'h00, 32'h4004, 32'h20);
        step(0, 1, 6'b100000, 32'h4008, 32'h0);
        chk("R10 nmi first", redir_pc, 32'h10);
        chk("R5 cause", cause, 32'hB0);
        step(0, 0, 6'b100000, 32'h400C, 32'h0);
        chk("R8 code 5", redir_pc, 32'hD0);

        // R1: reset request wins and drops pending
        step(0, 0, 6'h00, 32'h5000, 32'h0);
        step(0, 1, 6'b000001, 32'h5004, 32'h80);
        step(1, 1, 6'b000001, 32'h5008, 32'h0);
        chk("R1 pc", redir_pc, 32'h0);
        chk("R1 psw", new_psw, 32'h20);
        chk("R1 cause", cause, 32'h0);
        step(0, 1, 6'b000001, 32'h500C, 32'h0);
        chk("R1 pending dropped", 32'(redir_vld), 0);

        for (int c = 0; c < 4000; c++) begin
            logic [31:0] psw;
            logic [5:0]  irq;
            psw = $urandom & 32'hFFFF_FF5F;
            if ($urandom % 4 == 0) psw[7] = 1'b1;
            if ($urandom % 4 == 0) psw[5] = 1'b1;
            for (int b = 0; b < 6; b++) irq[b] = ($urandom % 4 == 0);
            step(($urandom % 200) == 0, ($urandom % 6) == 0, irq, $urandom, psw);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule